// File: doc/BRIEF.md
# Board Memory Address Remapper

This block sits between a 24-bit processor address and the board memory system. For each address, qualified as a read or a write, it picks one target: on-board RAM, boot ROM, the video window, channel memory, or nothing. For a RAM target it also returns the physical 1 MB block and the offset inside that block. The configuration is held in three small registers:

- a global RAM switch;
- a per-connector card register, which shows the card ID and holds two block enables;
- a control register, which holds the split-disable bit, the ROM-enable bit and the connector select.

Physical block 0 always serves the low 640 KB. The part of it above 640 KB is used in two pieces:

- Its top 128 KB backs the boot ROM window as a shadow.
- Its other 256 KB is relocated directly above the last packed megabyte.

Every other enabled physical block is packed, in index order, into consecutive megabytes starting at 1 MB. With ROM enabled, reads of the ROM window go to the ROM and writes go to the shadow. With ROM disabled, reads go to the shadow and writes are dropped.

Top module: `mem_remap`

## Requirements
- R1: After reset the registers read back as follows:
  - control register: 0x18 (split enabled, ROM enabled, bit 3 always reads 1, connector select 000);
  - RAM switch: 0x01;
  - card register: `{card_id[3:0], 2'b00, en[1:0]}` with both enables set.
- R2: Address ranges below 1 MB decode as follows:
  - 0x000000–0x09FFFF goes to RAM block 0 with offset equal to the address;
  - 0x0A0000–0x0BFFFF goes to video;
  - 0x0C0000–0x0DFFFF goes to channel.
- R3: With ROM enabled (control bit 4 = 1), a read in the ROM window goes to ROM and asserts the ROM select. A write in the window goes to RAM block 0 at offset 0x0E0000 + addr[16:0], provided the shadow is active.
- R4: With ROM disabled, a read in the ROM window goes to the shadow in RAM block 0. A write in the window gives target none.
- R5: The window 0xFE0000–0xFFFFFF behaves exactly like 0x0E0000–0x0FFFFF.
- R6: A control write that clears bit 4 leaves ROM enabled unless the stored split-disable bit (bit 5) is already 0.
- R7: Enabled physical blocks 1..3 are packed, lowest index first, into consecutive megabytes from 0x100000. A disabled block's megabyte goes to the next enabled block.
- R8: When block 0 is enabled and bit 5 is 0, the first 256 KB of the megabyte after the last packed one maps to block 0 at offset 0x0A0000 + addr[17:0]. Setting bit 5 to 1 removes both this split block and the ROM shadow.
- R9: When block 0 is disabled:
  - the low 640 KB goes to channel;
  - the split block and the shadow are off;
  - a shadow access with no ROM target gives target none.
- R10: RAM switch bit 0 = 0 disables every RAM block at once.
- R11: Control bits 2:0 pick which card register is accessed (000 = connector 1 = blocks 0/1, 001 = connector 2 = blocks 2/3). With any other value, card register writes are ignored and reads return 0xFF.
- R12: Card enable bit 0 enables the card's first megabyte. Bit 1 enables the second megabyte, but only on a 2 MB card. The card size comes from the card ID:
  - 0001 and 0101 are 2 MB cards;
  - 0010 and 0110 are 1 MB cards;
  - every other ID means no block is present.
- R13: Any address not claimed by the ranges above goes to channel. Target codes: 0 none, 1 RAM, 2 ROM, 3 video, 4 channel. Block index and offset are 0 unless the target is RAM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register select: 0 RAM switch, 1 card, 2 control |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Register read data for cfg_addr_i |
| card_id_i | input | 8 | 4-bit ID per connector, connector 1 in bits 3:0 |
| addr_i | input | 24 | Processor address |
| wr_i | input | 1 | 1 = write, 0 = read |
| tgt_o | output | 3 | Target code |
| ram_blk_o | output | 2 | Physical RAM block index |
| ram_off_o | output | 20 | Offset inside the RAM block |
| rom_sel_o | output | 1 | Boot ROM selected |

## Verification
The decode is combinational on the stored registers. A wrong register value therefore shows up on the first lookup after the write that caused it, with no delay beyond one edge.

A stuck or miscounted packing rank shifts a whole megabyte onto the wrong block index. A lost guard on the ROM-enable bit turns ROM reads into RAM reads in the very next cycle. The bench probes megabyte boundaries and both ends of each window after every configuration change, so such errors appear at the ports at once.

// File: rtl/mem_remap_pkg.sv
package mem_remap_pkg;
  typedef enum logic [2:0] {
    TGT_NONE  = 3'd0,
    TGT_RAM   = 3'd1,
    TGT_ROM   = 3'd2,
    TGT_VIDEO = 3'd3,
    TGT_CHAN  = 3'd4
  } tgt_e;

  localparam logic [1:0] CFG_MEMEN = 2'd0;
  localparam logic [1:0] CFG_CARD  = 2'd1;
  localparam logic [1:0] CFG_CTRL  = 2'd2;

  localparam int MB_PER_CARD = 2;

  // installed megabytes for a card ID
  function automatic logic [1:0] card_mb(input logic [3:0] id);
    case (id)
      4'b0001, 4'b0101: card_mb = 2'd2;
      4'b0010, 4'b0110: card_mb = 2'd1;
      default:          card_mb = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/mem_remap_regs.sv
module mem_remap_regs
  import mem_remap_pkg::*;
#(
  parameter int N_CONN = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [1:0]              addr_i,
  input  logic [7:0]              wdata_i,
  input  logic [N_CONN*4-1:0]     card_id_i,
  output logic [7:0]              rdata_o,
  output logic                    mem_on_o,
  output logic [N_CONN-1:0][1:0]  card_en_o,
  output logic                    rom_en_o,
  output logic                    split_dis_o
);
  logic                   mem_on_q, rom_en_q, split_dis_q;
  logic [2:0]             sel_q;
  logic [N_CONN-1:0][1:0] card_en_q;
  logic                   unused_wdata;

  assign unused_wdata = ^{wdata_i[7:6], wdata_i[3]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_on_q    <= 1'b1;
      rom_en_q    <= 1'b1;
      split_dis_q <= 1'b0;
      sel_q       <= 3'd0;
      card_en_q   <= '1;
    end else if (we_i) begin
      case (addr_i)
        CFG_MEMEN: mem_on_q <= wdata_i[0];
        CFG_CTRL: begin
          split_dis_q <= wdata_i[5];
          // ROM may only be turned off once the split RAM is already on
          rom_en_q    <= wdata_i[4] | (rom_en_q & split_dis_q);
          sel_q       <= wdata_i[2:0];
        end
        CFG_CARD: begin
          for (int c = 0; c < N_CONN; c++)
            if (sel_q == 3'(c)) card_en_q[c] <= wdata_i[1:0];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    case (addr_i)
      CFG_MEMEN: rdata_o = {7'd0, mem_on_q};
      CFG_CTRL:  rdata_o = {2'b00, split_dis_q, rom_en_q, 1'b1, sel_q};
      CFG_CARD: begin
        rdata_o = 8'hFF;
        for (int c = 0; c < N_CONN; c++)
          if (sel_q == 3'(c)) rdata_o = {card_id_i[4*c +: 4], 2'b00, card_en_q[c]};
      end
      default: ;
    endcase
  end

  assign mem_on_o    = mem_on_q;
  assign card_en_o   = card_en_q;
  assign rom_en_o    = rom_en_q;
  assign split_dis_o = split_dis_q;
endmodule

// File: rtl/mem_remap_blocks.sv
module mem_remap_blocks
  import mem_remap_pkg::*;
#(
  parameter int N_CONN = 2,
  localparam int N_BLK = N_CONN * MB_PER_CARD
) (
  input  logic                   mem_on_i,
  input  logic [N_CONN-1:0][1:0] card_en_i,
  input  logic [N_CONN*4-1:0]    card_id_i,
  output logic [N_BLK-1:0]       blk_en_o
);
  for (genvar c = 0; c < N_CONN; c++) begin : g_conn
    logic [1:0] cap;
    assign cap = card_mb(card_id_i[4*c +: 4]);
    assign blk_en_o[2*c]   = mem_on_i & card_en_i[c][0] & (cap != 2'd0);
    assign blk_en_o[2*c+1] = mem_on_i & card_en_i[c][1] & (cap == 2'd2);
  end
endmodule

// File: rtl/mem_remap_decode.sv
module mem_remap_decode
  import mem_remap_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int N_BLK  = 4,
  localparam int MB_W  = ADDR_W - 20,
  localparam int BLK_W = $clog2(N_BLK)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [N_BLK-1:0]  blk_en_i,
  input  logic              rom_en_i,
  input  logic              split_dis_i,
  output tgt_e              tgt_o,
  output logic [BLK_W-1:0]  blk_o,
  output logic [19:0]       off_o
);
  localparam logic [MB_W:0] ONE = 1;

  logic [MB_W-1:0] mb;
  logic            low, rom_win, shadow_on, pk_hit, split_hit;
  logic [MB_W:0]   cnt, rank;
  logic [BLK_W-1:0] pk_blk;

  assign mb        = addr_i[ADDR_W-1:20];
  assign low       = (mb == '0);
  assign rom_win   = (low && addr_i[19:17] == 3'b111) || (&addr_i[ADDR_W-1:17]);
  assign shadow_on = blk_en_i[0] & ~split_dis_i;

  // rank search over blocks 1..N_BLK-1; block 0 is the low megabyte
  always_comb begin
    cnt    = '0;
    pk_hit = 1'b0;
    pk_blk = '0;
    rank   = {1'b0, mb} - ONE;
    for (int p = 1; p < N_BLK; p++) begin
      if (blk_en_i[p]) begin
        if (!pk_hit && cnt == rank) begin
          pk_hit = 1'b1;
          pk_blk = BLK_W'(p);
        end
        cnt = cnt + ONE;
      end
    end
    split_hit = shadow_on && ({1'b0, mb} == cnt + ONE) && (addr_i[19:18] == 2'b00);
  end

  always_comb begin
    tgt_o = TGT_NONE;
    blk_o = '0;
    off_o = '0;
    if (rom_win) begin
      if (!wr_i && rom_en_i) tgt_o = TGT_ROM;
      else if (wr_i && !rom_en_i) tgt_o = TGT_NONE;
      else if (shadow_on) begin
        tgt_o = TGT_RAM;
        off_o = {3'b111, addr_i[16:0]};
      end
    end else if (low) begin
      if (addr_i[19:0] < 20'hA0000) begin
        if (blk_en_i[0]) begin
          tgt_o = TGT_RAM;
          off_o = addr_i[19:0];
        end else tgt_o = TGT_CHAN;
      end else if (addr_i[19:0] < 20'hC0000) tgt_o = TGT_VIDEO;
      else tgt_o = TGT_CHAN;
    end else if (pk_hit) begin
      tgt_o = TGT_RAM;
      blk_o = pk_blk;
      off_o = addr_i[19:0];
    end else if (split_hit) begin
      tgt_o = TGT_RAM;
      off_o = 20'hA0000 + {2'b00, addr_i[17:0]};
    end else tgt_o = TGT_CHAN;
  end
endmodule

// File: rtl/mem_remap.sv
module mem_remap
  import mem_remap_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int N_CONN = 2,
  localparam int N_BLK = N_CONN * MB_PER_CARD,
  localparam int BLK_W = $clog2(N_BLK)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [1:0]          cfg_addr_i,
  input  logic [7:0]          cfg_wdata_i,
  output logic [7:0]          cfg_rdata_o,
  input  logic [N_CONN*4-1:0] card_id_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_i,
  output logic [2:0]          tgt_o,
  output logic [BLK_W-1:0]    ram_blk_o,
  output logic [19:0]         ram_off_o,
  output logic                rom_sel_o
);
  logic                   mem_on, rom_en, split_dis;
  logic [N_CONN-1:0][1:0] card_en;
  logic [N_BLK-1:0]       blk_en;
  tgt_e                   tgt;

  mem_remap_regs #(.N_CONN(N_CONN)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .card_id_i, .rdata_o(cfg_rdata_o),
    .mem_on_o(mem_on), .card_en_o(card_en),
    .rom_en_o(rom_en), .split_dis_o(split_dis)
  );

  mem_remap_blocks #(.N_CONN(N_CONN)) u_blocks (
    .mem_on_i(mem_on), .card_en_i(card_en), .card_id_i, .blk_en_o(blk_en)
  );

  mem_remap_decode #(.ADDR_W(ADDR_W), .N_BLK(N_BLK)) u_dec (
    .addr_i, .wr_i, .blk_en_i(blk_en), .rom_en_i(rom_en),
    .split_dis_i(split_dis), .tgt_o(tgt), .blk_o(ram_blk_o), .off_o(ram_off_o)
  );

  assign tgt_o     = tgt;
  assign rom_sel_o = (tgt == TGT_ROM);
endmodule

// File: rtl/mem_remap_chk.sv
module mem_remap_chk
  import mem_remap_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int N_BLK  = 4,
  localparam int MB_W  = ADDR_W - 20,
  localparam int BLK_W = $clog2(N_BLK)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic [2:0]        tgt_o,
  input logic [BLK_W-1:0]  ram_blk_o,
  input logic [19:0]       ram_off_o,
  input logic              cfg_we_i,
  input logic [1:0]        cfg_addr_i,
  input logic              wdata_rom_bit,
  input logic              rom_en,
  input logic              split_dis,
  input logic              mem_on
);
  logic mirror, in_win, in_video, far_high;
  assign mirror   = &addr_i[ADDR_W-1:17];
  assign in_win   = mirror || (addr_i[ADDR_W-1:20] == '0 && addr_i[19:17] == 3'b111);
  assign in_video = (addr_i[ADDR_W-1:20] == '0) && (addr_i[19:17] == 3'b101);
  assign far_high = (addr_i[ADDR_W-1:20] > MB_W'(N_BLK)) && !mirror;

  AST_ROM_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_o == TGT_ROM |-> !wr_i); // R3
  AST_DROP_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_win && wr_i && !rom_en) |-> tgt_o == TGT_NONE); // R4
  AST_VIDEO_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_video |-> tgt_o == TGT_VIDEO); // R2
  AST_ROM_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == CFG_CTRL && split_dis && rom_en && !wdata_rom_bit) |=> rom_en); // R6
  AST_RAM_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_on |-> tgt_o != TGT_RAM); // R10
  AST_IDLE_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_o != TGT_RAM |-> (ram_blk_o == '0 && ram_off_o == '0)); // R13
  AST_FAR_CHAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    far_high |-> tgt_o == TGT_CHAN); // R13
endmodule

bind mem_remap mem_remap_chk #(.ADDR_W(ADDR_W), .N_BLK(N_BLK)) u_chk (
  .clk_i, .rst_ni, .addr_i, .wr_i, .tgt_o, .ram_blk_o, .ram_off_o,
  .cfg_we_i, .cfg_addr_i, .wdata_rom_bit(cfg_wdata_i[4]),
  .rom_en, .split_dis, .mem_on
);

// File: tb/sim_mem_remap.sv
module sim_mem_remap;
  localparam logic [2:0] T_NONE = 3'd0, T_RAM = 3'd1, T_ROM = 3'd2,
                         T_VID = 3'd3, T_CHAN = 3'd4;
  localparam logic [1:0] A_MEM = 2'd0, A_CARD = 2'd1, A_CTRL = 2'd2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [7:0]  cfg_wdata = 8'd0;
  logic [7:0]  cfg_rdata;
  logic [7:0]  card_id = {4'b0010, 4'b0001};
  logic [23:0] addr = 24'd0;
  logic        wr = 1'b0;
  logic [2:0]  tgt;
  logic [1:0]  blk;
  logic [19:0] off;
  logic        rom_sel;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  mem_remap u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .card_id_i(card_id),
    .addr_i(addr), .wr_i(wr), .tgt_o(tgt), .ram_blk_o(blk),
    .ram_off_o(off), .rom_sel_o(rom_sel)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wcfg(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rcfg(string tag, logic [1:0] a, logic [7:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(tag, {24'd0, cfg_rdata}, {24'd0, exp});
  endtask

  task automatic look(string tag, logic [23:0] a, logic w,
                      logic [2:0] et, logic [1:0] eb, logic [19:0] eo);
    @(negedge clk);
    addr = a; wr = w;
    #1;
    chk(tag, {6'd0, rom_sel, tgt, blk, off}, {6'd0, (et == T_ROM), et, eb, eo});
  endtask

  task automatic t_reset;
    rcfg("R1 ctrl", A_CTRL, 8'h18);
    rcfg("R1 memen", A_MEM, 8'h01);
    rcfg("R1 card", A_CARD, 8'h13);
  endtask

  task automatic t_low;
    look("R2 ram0", 24'h012345, 1'b0, T_RAM, 2'd0, 20'h12345);
    look("R2 ram top", 24'h09FFFF, 1'b1, T_RAM, 2'd0, 20'h9FFFF);
    look("R2 video lo", 24'h0A1000, 1'b0, T_VID, 2'd0, 20'h0);
    look("R2 video hi", 24'h0BFFFF, 1'b1, T_VID, 2'd0, 20'h0);
    look("R2 chan lo", 24'h0C0000, 1'b0, T_CHAN, 2'd0, 20'h0);
    look("R2 chan hi", 24'h0DFFFF, 1'b0, T_CHAN, 2'd0, 20'h0);
  endtask

  task automatic t_rom;
    look("R3 rd", 24'h0E1234, 1'b0, T_ROM, 2'd0, 20'h0);
    look("R3 wr", 24'h0E1234, 1'b1, T_RAM, 2'd0, 20'hE1234);
    look("R5 rd", 24'hFE1234, 1'b0, T_ROM, 2'd0, 20'h0);
    look("R5 wr", 24'hFE1234, 1'b1, T_RAM, 2'd0, 20'hE1234);
    look("R5 wr top", 24'hFFFFFF, 1'b1, T_RAM, 2'd0, 20'hFFFFF);
  endtask

  task automatic t_pack;
    look("R7 mb1", 24'h150000, 1'b0, T_RAM, 2'd1, 20'h50000);
    look("R7 mb2", 24'h2ABCDE, 1'b0, T_RAM, 2'd2, 20'hABCDE);
    look("R8 split", 24'h312345, 1'b0, T_RAM, 2'd0, 20'hB2345);
    look("R8 split end", 24'h33FFFF, 1'b1, T_RAM, 2'd0, 20'hDFFFF);
    look("R13 after split", 24'h340000, 1'b0, T_CHAN, 2'd0, 20'h0);
    look("R13 high", 24'h500000, 1'b0, T_CHAN, 2'd0, 20'h0);
  endtask

  task automatic t_skip;
    wcfg(A_CARD, 8'h01);
    rcfg("R11 card rd", A_CARD, 8'h11);
    look("R7 skip", 24'h150000, 1'b0, T_RAM, 2'd2, 20'h50000);
    look("R8 split moved", 24'h200010, 1'b0, T_RAM, 2'd0, 20'hA0010);
    look("R8 split limit", 24'h2ABCDE, 1'b0, T_CHAN, 2'd0, 20'h0);
    look("R13 mb3", 24'h300000, 1'b0, T_CHAN, 2'd0, 20'h0);
  endtask

  task automatic t_guard;
    wcfg(A_CTRL, 8'h38);
    rcfg("R6 set", A_CTRL, 8'h38);
    wcfg(A_CTRL, 8'h28);
    rcfg("R6 kept", A_CTRL, 8'h38);
    look("R8 no shadow wr", 24'h0E1234, 1'b1, T_NONE, 2'd0, 20'h0);
    look("R6 rom still", 24'h0E1234, 1'b0, T_ROM, 2'd0, 20'h0);
    look("R8 no split", 24'h200010, 1'b0, T_CHAN, 2'd0, 20'h0);
    wcfg(A_CTRL, 8'h18);
    rcfg("R6 split on", A_CTRL, 8'h18);
    wcfg(A_CTRL, 8'h08);
    rcfg("R6 rom off", A_CTRL, 8'h08);
  endtask

  task automatic t_romoff;
    look("R4 rd", 24'h0E1234, 1'b0, T_RAM, 2'd0, 20'hE1234);
    look("R4 wr", 24'h0E1234, 1'b1, T_NONE, 2'd0, 20'h0);
    look("R5 off rd", 24'hFE0000, 1'b0, T_RAM, 2'd0, 20'hE0000);
    look("R5 off wr", 24'hFE0000, 1'b1, T_NONE, 2'd0, 20'h0);
  endtask

  task automatic t_memoff;
    wcfg(A_MEM, 8'h00);
    rcfg("R10 rd", A_MEM, 8'h00);
    look("R10 low", 24'h012345, 1'b0, T_CHAN, 2'd0, 20'h0);
    look("R10 mb1", 24'h150000, 1'b0, T_CHAN, 2'd0, 20'h0);
    look("R9 shadow none", 24'h0E1234, 1'b0, T_NONE, 2'd0, 20'h0);
    look("R9 no split", 24'h100000, 1'b0, T_CHAN, 2'd0, 20'h0);
    wcfg(A_MEM, 8'h01);
    look("R10 back", 24'h012345, 1'b0, T_RAM, 2'd0, 20'h12345);
  endtask

  task automatic t_sel;
    wcfg(A_CTRL, 8'h19);
    rcfg("R11 ctrl", A_CTRL, 8'h19);
    rcfg("R11 conn2", A_CARD, 8'h23);
    wcfg(A_CARD, 8'h00);
    rcfg("R11 conn2 off", A_CARD, 8'h20);
    look("R8 split at mb1", 24'h100020, 1'b0, T_RAM, 2'd0, 20'hA0020);
    look("R8 split past", 24'h140000, 1'b0, T_CHAN, 2'd0, 20'h0);
    wcfg(A_CTRL, 8'h1A);
    rcfg("R11 rsvd rd", A_CARD, 8'hFF);
    wcfg(A_CARD, 8'h03);
    wcfg(A_CTRL, 8'h19);
    rcfg("R11 rsvd wr ignored", A_CARD, 8'h20);
    look("R11 map unchanged", 24'h100020, 1'b0, T_RAM, 2'd0, 20'hA0020);
  endtask

  task automatic t_cap;
    wcfg(A_CARD, 8'h03);
    look("R12 1mb card", 24'h100000, 1'b0, T_RAM, 2'd2, 20'h00000);
    look("R12 split after", 24'h23FFFF, 1'b0, T_RAM, 2'd0, 20'hDFFFF);
    look("R12 split end", 24'h240000, 1'b0, T_CHAN, 2'd0, 20'h0);
    look("R12 no 2nd mb", 24'h300000, 1'b0, T_CHAN, 2'd0, 20'h0);
  endtask

  task automatic t_absent;
    @(negedge clk);
    card_id = {4'b0010, 4'b1111};
    look("R9 low chan", 24'h012345, 1'b0, T_CHAN, 2'd0, 20'h0);
    look("R12 absent pack", 24'h100000, 1'b0, T_RAM, 2'd2, 20'h0);
    look("R9 split off", 24'h200000, 1'b0, T_CHAN, 2'd0, 20'h0);
    look("R9 rom rd", 24'h0E1234, 1'b0, T_ROM, 2'd0, 20'h0);
    look("R9 shadow wr", 24'h0E1234, 1'b1, T_NONE, 2'd0, 20'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_low();
    t_rom();
    t_pack();
    t_skip();
    t_guard();
    t_romoff();
    t_memoff();
    t_sel();
    t_cap();
    t_absent();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule